// File: doc/BRIEF.md
# Branch and Literal Target Calculator

The block takes one 16-bit instruction (two bytes in either byte order), the address of that instruction, and a register value supplied by an external register file. It decides whether the instruction is a control transfer or a PC-relative literal load. For those instructions it works out the branch target or the literal address.

Its outputs are registered once and give:
- the instruction class,
- whether the transfer is conditional, and if so whether it is taken on a true or a false flag,
- whether it is a delayed-slot form,
- the 32-bit address.

The block itself evaluates no condition flag, reads no register and makes no memory access. The register index in bits 11:8 is brought out combinationally, so the register file can return the value in the same cycle.

Top module: `br_tgt_calc`

## Requirements
- R1: With `big_endian_i`=1 the instruction word is `{instr_bytes_i[7:0], instr_bytes_i[15:8]}`; with 0 it is `instr_bytes_i` unchanged. `reg_sel_o` is word bits 11:8 in the same cycle.
- R2: When word bits 15:12 are 0x8 and bits 11:8 are 0x9, 0xB, 0xD or 0xF, the output is a conditional branch:
  - `class_o`=1 and `cond_o`=1;
  - `on_true_o`=1 for 0x9 and 0xD, and 0 for 0xB and 0xF;
  - `delayed_o`=1 for 0xD and 0xF only.
  Every other sub-code in bits 11:8 gives class 0.
- R3: The conditional branch target is PC + 4 + 2 × sign-extended bits 7:0.
- R4: Major code 0xA gives `class_o`=2 and 0xB gives `class_o`=3. For both the target is PC + 4 + 2 × sign-extended bits 11:0, with `cond_o`=0 and `delayed_o`=0.
- R5: Major code 0x9 gives `class_o`=4, address (PC with bit 0 cleared) + 4 + 2 × zero-extended bits 7:0.
- R6: Major code 0xD gives `class_o`=5, address (PC with bits 1:0 cleared) + 4 + 4 × zero-extended bits 7:0.
- R7: Major code 0x4 with low byte 0x2B gives `class_o`=6, and the target is `rn_val_i`. Any other low byte under 0x4 gives class 0.
- R8: Any instruction not covered by R2 to R7 gives `class_o`=0, `target_o`=0, and `cond_o`, `on_true_o` and `delayed_o` all 0.
- R9: All address arithmetic is 32-bit and wraps modulo 2^32.
- R10: Outputs change one clock edge after an edge where `valid_i`=1, and `valid_o` follows `valid_i` with one cycle of delay. When `valid_i`=0 the class, flag and target outputs hold their values.
- R11: While `rst_ni` is low all registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction inputs are valid this cycle |
| big_endian_i | input | 1 | Byte order of `instr_bytes_i` |
| instr_bytes_i | input | 16 | Instruction bytes; the byte at the lower address is in [7:0] |
| pc_i | input | 32 | Address of the instruction |
| rn_val_i | input | 32 | Value of the register named by `reg_sel_o` |
| reg_sel_o | output | 4 | Register index taken from word bits 11:8 (combinational) |
| valid_o | output | 1 | Registered result valid |
| class_o | output | 3 | Instruction class (0 to 6) |
| cond_o | output | 1 | Conditional transfer |
| on_true_o | output | 1 | Conditional transfer is taken on a true flag |
| delayed_o | output | 1 | Delayed-slot form |
| target_o | output | 32 | Target or literal address |

## Verification
The checks on the R7 register value assume `rn_val_i` is driven in the same cycle as its instruction, since the external register file answers combinationally. The bench therefore always presents the instruction, PC and register value together, on one falling edge. The hold checks assume the inputs may change freely while `valid_i` is low, so the bench deliberately drives unrelated instruction words in idle cycles. The alignment checks depend only on the arithmetic, so the stimulus includes odd and misaligned PC values and displacements at both extremes.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_CBR   = 3'd1,
    CLS_BRA   = 3'd2,
    CLS_BSR   = 3'd3,
    CLS_LIT_W = 3'd4,
    CLS_LIT_L = 3'd5,
    CLS_JREG  = 3'd6
  } cls_e;

  typedef struct packed {
    cls_e cls;
    logic cond;
    logic on_true;
    logic delayed;
  } dec_t;
endpackage

// File: rtl/br_word_asm.sv
module br_word_asm #(
  parameter int IW = 16
) (
  input  logic          big_endian_i,
  input  logic [IW-1:0] bytes_i,
  output logic [IW-1:0] word_o
);
  localparam int NB = IW / 8;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign word_o[i*8 +: 8] = big_endian_i ? bytes_i[(NB-1-i)*8 +: 8] : bytes_i[i*8 +: 8];
  end
endmodule

// File: rtl/br_decode.sv
module br_decode
  import br_pkg::*;
(
  input  logic [15:0] word_i,
  output dec_t        dec_o
);
  logic [3:0] major, sub;
  logic [7:0] low8;

  assign major = word_i[15:12];
  assign sub   = word_i[11:8];
  assign low8  = word_i[7:0];

  always_comb begin
    dec_o = '{cls: CLS_NONE, cond: 1'b0, on_true: 1'b0, delayed: 1'b0};
    unique case (major)
      4'h8: if (sub[3] && sub[0]) begin
        // sub-codes 9,B,D,F: bit1 selects false, bit2 selects delayed slot
        dec_o.cls     = CLS_CBR;
        dec_o.cond    = 1'b1;
        dec_o.on_true = ~sub[1];
        dec_o.delayed = sub[2];
      end
      4'hA: dec_o.cls = CLS_BRA;
      4'hB: dec_o.cls = CLS_BSR;
      4'h9: dec_o.cls = CLS_LIT_W;
      4'hD: dec_o.cls = CLS_LIT_L;
      4'h4: if (low8 == 8'h2B) dec_o.cls = CLS_JREG;
      default: ;
    endcase
  end
endmodule

// File: rtl/br_addr.sv
module br_addr
  import br_pkg::*;
#(
  parameter int AW = 32
) (
  input  cls_e          cls_i,
  input  logic [11:0]   field_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] rn_val_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] PC_BIAS = AW'(4);

  logic [AW-1:0] sdisp8, sdisp12, zdisp_w, zdisp_l, pc_w, pc_l, pc_b;

  assign sdisp8  = {{(AW-9){field_i[7]}}, field_i[7:0], 1'b0};
  assign sdisp12 = {{(AW-13){field_i[11]}}, field_i, 1'b0};
  assign zdisp_w = {{(AW-9){1'b0}}, field_i[7:0], 1'b0};
  assign zdisp_l = {{(AW-10){1'b0}}, field_i[7:0], 2'b00};
  assign pc_b    = pc_i + PC_BIAS;
  assign pc_w    = {pc_i[AW-1:1], 1'b0} + PC_BIAS;
  assign pc_l    = {pc_i[AW-1:2], 2'b00} + PC_BIAS;

  always_comb begin
    unique case (cls_i)
      CLS_CBR:          addr_o = pc_b + sdisp8;
      CLS_BRA, CLS_BSR: addr_o = pc_b + sdisp12;
      CLS_LIT_W:        addr_o = pc_w + zdisp_w;
      CLS_LIT_L:        addr_o = pc_l + zdisp_l;
      CLS_JREG:         addr_o = rn_val_i;
      default:          addr_o = '0;
    endcase
  end
endmodule

// File: rtl/br_tgt_calc.sv
module br_tgt_calc
  import br_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          big_endian_i,
  input  logic [IW-1:0] instr_bytes_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] rn_val_i,
  output logic [3:0]    reg_sel_o,
  output logic          valid_o,
  output logic [2:0]    class_o,
  output logic          cond_o,
  output logic          on_true_o,
  output logic          delayed_o,
  output logic [AW-1:0] target_o
);
  logic [IW-1:0] word;
  dec_t          dec;
  logic [AW-1:0] addr;

  br_word_asm #(.IW(IW)) u_asm (
    .big_endian_i (big_endian_i),
    .bytes_i      (instr_bytes_i),
    .word_o       (word)
  );

  br_decode u_dec (
    .word_i (word),
    .dec_o  (dec)
  );

  br_addr #(.AW(AW)) u_addr (
    .cls_i    (dec.cls),
    .field_i  (word[11:0]),
    .pc_i     (pc_i),
    .rn_val_i (rn_val_i),
    .addr_o   (addr)
  );

  assign reg_sel_o = word[11:8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      class_o   <= '0;
      cond_o    <= 1'b0;
      on_true_o <= 1'b0;
      delayed_o <= 1'b0;
      target_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        class_o   <= dec.cls;
        cond_o    <= dec.cond;
        on_true_o <= dec.on_true;
        delayed_o <= dec.delayed;
        target_o  <= addr;
      end
    end
  end
endmodule

// File: rtl/br_tgt_calc_chk.sv
module br_tgt_calc_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [AW-1:0] rn_val_i,
  input logic          valid_o,
  input logic [2:0]    class_o,
  input logic          cond_o,
  input logic          on_true_o,
  input logic          delayed_o,
  input logic [AW-1:0] target_o
);
  // R8
  none_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && class_o == 3'd0) |-> (target_o == '0 && !cond_o && !on_true_o && !delayed_o));

  // R2
  cond_cls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_o || delayed_o || on_true_o) |-> (class_o == 3'd1 && cond_o));

  // R5
  lit_w_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && class_o == 3'd4) |-> !target_o[0]);

  // R6
  lit_l_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && class_o == 3'd5) |-> target_o[1:0] == 2'b00);

  // R7
  jreg_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && class_o == 3'd6) |-> target_o == $past(rn_val_i));

  // R10
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(target_o) && $stable(class_o) && $stable(cond_o)));
endmodule

bind br_tgt_calc br_tgt_calc_chk #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .rn_val_i  (rn_val_i),
  .valid_o   (valid_o),
  .class_o   (class_o),
  .cond_o    (cond_o),
  .on_true_o (on_true_o),
  .delayed_o (delayed_o),
  .target_o  (target_o)
);

// File: tb/br_tgt_calc_bench.sv
module br_tgt_calc_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        big_endian_i = 1'b0;
  logic [15:0] instr_bytes_i = '0;
  logic [31:0] pc_i = '0;
  logic [31:0] rn_val_i = '0;
  logic [3:0]  reg_sel_o;
  logic        valid_o;
  logic [2:0]  class_o;
  logic        cond_o, on_true_o, delayed_o;
  logic [31:0] target_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  br_tgt_calc u_br_tgt_calc (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .valid_i       (valid_i),
    .big_endian_i  (big_endian_i),
    .instr_bytes_i (instr_bytes_i),
    .pc_i          (pc_i),
    .rn_val_i      (rn_val_i),
    .reg_sel_o     (reg_sel_o),
    .valid_o       (valid_o),
    .class_o       (class_o),
    .cond_o        (cond_o),
    .on_true_o     (on_true_o),
    .delayed_o     (delayed_o),
    .target_o      (target_o)
  );

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  task automatic model(input logic [15:0] w, input logic [31:0] pc, input logic [31:0] rn,
                       output logic [2:0] c, output logic cnd, output logic tru,
                       output logic dly, output logic [31:0] t);
    logic [3:0]  hi, s;
    logic [7:0]  lo;
    logic [31:0] d8, d12;
    hi = w[15:12]; s = w[11:8]; lo = w[7:0];
    d8  = {{24{lo[7]}}, lo};
    d12 = {{20{w[11]}}, w[11:0]};
    c = 3'd0; cnd = 1'b0; tru = 1'b0; dly = 1'b0; t = '0;
    if (hi == 4'h8 && (s == 4'h9 || s == 4'hB || s == 4'hD || s == 4'hF)) begin
      c = 3'd1; cnd = 1'b1;
      tru = (s == 4'h9 || s == 4'hD);
      dly = (s == 4'hD || s == 4'hF);
      t = pc + 32'd4 + (d8 << 1);
    end else if (hi == 4'hA || hi == 4'hB) begin
      c = (hi == 4'hA) ? 3'd2 : 3'd3;
      t = pc + 32'd4 + (d12 << 1);
    end else if (hi == 4'h9) begin
      c = 3'd4;
      t = (pc & 32'hFFFF_FFFE) + 32'd4 + {23'd0, lo, 1'b0};
    end else if (hi == 4'hD) begin
      c = 3'd5;
      t = (pc & 32'hFFFF_FFFC) + 32'd4 + {22'd0, lo, 2'b00};
    end else if (hi == 4'h4 && lo == 8'h2B) begin
      c = 3'd6;
      t = rn;
    end
  endtask

  // drive at a falling edge, check after the next rising edge (one register)
  task automatic apply(input string req, input logic [15:0] w, input logic be,
                       input logic [31:0] pc, input logic [31:0] rn);
    logic [2:0]  c;
    logic        cnd, tru, dly;
    logic [31:0] t;
    model(w, pc, rn, c, cnd, tru, dly, t);
    @(negedge clk);
    big_endian_i  = be;
    instr_bytes_i = be ? {w[7:0], w[15:8]} : w;
    pc_i     = pc;
    rn_val_i = rn;
    valid_i  = 1'b1;
    #1;
    check("R1", "reg_sel", {28'd0, reg_sel_o}, {28'd0, w[11:8]});
    @(negedge clk);
    valid_i = 1'b0;
    check("R10", "valid", {31'd0, valid_o}, 32'd1);
    check(req, "class", {29'd0, class_o}, {29'd0, c});
    check(req, "cond", {31'd0, cond_o}, {31'd0, cnd});
    check(req, "on_true", {31'd0, on_true_o}, {31'd0, tru});
    check(req, "delayed", {31'd0, delayed_o}, {31'd0, dly});
    check(req, "target", target_o, t);
  endtask

  task automatic t_reset;
    check("R11", "valid", {31'd0, valid_o}, 32'd0);
    check("R11", "class", {29'd0, class_o}, 32'd0);
    check("R11", "target", target_o, 32'd0);
  endtask

  task automatic t_cond;
    apply("R2", 16'h8905, 1'b0, 32'h0000_1000, 32'd0);
    apply("R2", 16'h8BFE, 1'b1, 32'h0000_2000, 32'd0);
    apply("R2", 16'h8D7F, 1'b0, 32'h0000_3002, 32'd0);
    apply("R3", 16'h8F80, 1'b1, 32'h0000_4000, 32'd0);
    check("R3", "neg disp", target_o, 32'h0000_3F04);
    apply("R2", 16'h8812, 1'b0, 32'h0000_5000, 32'd0);
    apply("R2", 16'h8A12, 1'b0, 32'h0000_5000, 32'd0);
  endtask

  task automatic t_bra;
    apply("R4", 16'hA800, 1'b0, 32'h0000_1000, 32'd0);
    check("R4", "max neg", target_o, 32'h0000_0004);
    apply("R4", 16'hA7FF, 1'b1, 32'h1000_0000, 32'd0);
    apply("R4", 16'hB010, 1'b0, 32'h0000_0100, 32'd0);
    apply("R4", 16'hBFFF, 1'b1, 32'h0000_0100, 32'd0);
  endtask

  task automatic t_lit;
    apply("R5", 16'h9301, 1'b0, 32'h0000_1001, 32'd0);
    check("R5", "odd pc", target_o, 32'h0000_1006);
    apply("R5", 16'h92FF, 1'b1, 32'h0000_2000, 32'd0);
    apply("R6", 16'hD001, 1'b0, 32'h0000_1003, 32'd0);
    check("R6", "misaligned pc", target_o, 32'h0000_1008);
    apply("R6", 16'hD5FF, 1'b1, 32'h0000_2002, 32'd0);
  endtask

  task automatic t_jreg;
    apply("R7", 16'h4A2B, 1'b0, 32'h0000_1000, 32'hCAFE_0123);
    apply("R7", 16'h432B, 1'b1, 32'h0000_1000, 32'h8000_0001);
    apply("R7", 16'h4A2A, 1'b0, 32'h0000_1000, 32'hCAFE_0123);
  endtask

  task automatic t_other;
    apply("R8", 16'h6123, 1'b0, 32'h0000_1000, 32'h1234_5678);
    apply("R8", 16'h0009, 1'b1, 32'hFFFF_0000, 32'h1234_5678);
    apply("R8", 16'hE1FF, 1'b0, 32'h0000_0010, 32'd0);
  endtask

  task automatic t_wrap;
    apply("R9", 16'hA001, 1'b0, 32'hFFFF_FFFE, 32'd0);
    check("R9", "wrap up", target_o, 32'h0000_0004);
    apply("R9", 16'h8980, 1'b0, 32'h0000_0010, 32'd0);
    check("R9", "wrap down", target_o, 32'hFFFF_FF14);
  endtask

  task automatic t_hold;
    logic [31:0] t0;
    apply("R10", 16'hD010, 1'b0, 32'h0000_0100, 32'd0);
    t0 = target_o;
    @(negedge clk);
    instr_bytes_i = 16'h8905;
    pc_i = 32'h5555_0000;
    valid_i = 1'b0;
    @(negedge clk);
    check("R10", "valid low", {31'd0, valid_o}, 32'd0);
    check("R10", "held target", target_o, t0);
    check("R10", "held class", {29'd0, class_o}, 32'd5);
    check("R10", "held cond", {31'd0, cond_o}, 32'd0);
  endtask

  task automatic t_mid_reset;
    apply("R11", 16'h8D01, 1'b0, 32'h0000_0100, 32'd0);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R11", "valid", {31'd0, valid_o}, 32'd0);
    check("R11", "target", target_o, 32'd0);
    check("R11", "cond", {31'd0, cond_o}, 32'd0);
    check("R11", "delayed", {31'd0, delayed_o}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_cond();
    t_bra();
    t_lit();
    t_jreg();
    t_other();
    t_wrap();
    t_hold();
    t_mid_reset();
    apply("R1", 16'hB123, 1'b1, 32'h0000_0800, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule